// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block sits between the peripherals of a small 16-bit microcontroller and its CPU. It keeps one request flag and one enable bit for each interrupt source and adds a global interrupt enable. Each cycle it picks the highest-priority pending request and presents the 16-bit word address of that request's vector to the CPU, together with a request strobe. It does not fetch the vector from memory.

There are sixteen priority slots. Slot 15 is the reset slot: it is raised after power-up, by a system reset request, and by a watchdog overflow while the watchdog runs in watchdog mode. Slot 14 is a non-maskable group shared by three sources. These three sources have their own enables but do not depend on the global enable. The watchdog source can also act as an ordinary interval-timer interrupt. The CPU pulses an acknowledge while the strobe is high. On that acknowledge, the flag of a source that owns its vector alone is cleared. Flags of vectors that several sources share stay set until software clears them.

Flag set pulses come from the peripherals. Software clears flags with a clear mask and writes the enable register through a simple write strobe. The CPU core, the vector fetch and the peripherals are modelled only as these inputs.

Top module: `irq_vec_ctrl`

## Requirements
- R1: The vector address is 0xFFE0 + 2*slot. The flag and enable bit index of each source, and its slot, are: 0 basic timer slot 0; 1 port 2 slot 1; 2 DAC/DMA slot 3; 3 port 1 slot 4; 4 timer A other slot 5; 5 timer A CC0 slot 6; 6 ADC slot 7; 7 serial transmit slot 8; 8 serial receive slot 9; 9 watchdog slot 10; 10 comparator slot 11; 11 timer B other slot 12; 12 timer B CC0 slot 13; 13 NMI pin, 14 oscillator fault and 15 flash access violation share slot 14. Slot 2 has no source, and slot 15 (0xFFFE) is the reset slot.
- R2: After reset is released, the reset slot is pending, so `irq_o` rises with `vec_o` = 0xFFFE one clock edge later. A `sys_rst_req_i` pulse raises the reset slot again, regardless of enables and `gie_i`. Acknowledging 0xFFFE clears the reset slot.
- R3: While reset is held, `flags_o` = 0x4080 (transmit bit 7 and oscillator-fault bit 14 set) and `ie_o` = 0x0000.
- R4: When several enabled requests are pending, the highest slot wins. A flag set at one edge shows on `irq_o`/`vec_o` after the following edge.
- R5: Requests in slots 0 to 13 are forwarded only while `gie_i` is high.
- R6: A source in slot 14 needs its own enable bit but is forwarded with `gie_i` low.
- R7: With `wdt_intv_i` low (watchdog mode), watchdog enable bit 9 has no effect, and a `wdt_ovf_i` pulse raises the reset slot. With `wdt_intv_i` high, flag 9 with enable 9 requests 0xFFF4.
- R8: Acknowledging the vector of a single-source slot (bits 0, 5, 7, 8, 9, 10, 12) clears that flag. Flags of shared slots (bits 1, 2, 3, 4, 6, 11, 13, 14, 15) stay set.
- R9: In the cycle after an acknowledge, `irq_o` is low. The next cycle it reflects the remaining requests again.
- R10: During the acknowledge cycle, `vec_o` holds the vector it presented, even if a higher-priority request appears in that cycle.
- R11: A bit of `flag_clr_i` clears that flag at the next edge. A set pulse on the same bit in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| gie_i | input | 1 | Global enable for maskable slots |
| sys_rst_req_i | input | 1 | System reset request pulse (external reset, key violation) |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse |
| wdt_intv_i | input | 1 | 1 = watchdog as interval timer, 0 = watchdog mode |
| flag_set_i | input | 16 | Per-source flag set pulses |
| flag_clr_i | input | 16 | Per-source software clear mask |
| ie_we_i | input | 1 | Enable register write strobe |
| ie_data_i | input | 16 | Enable register write data |
| ack_i | input | 1 | CPU acknowledge of the presented vector |
| irq_o | output | 1 | Interrupt request strobe to the CPU |
| vec_o | output | 16 | Vector word address |
| flags_o | output | 16 | Current flag register |
| ie_o | output | 16 | Current enable register |

## Verification
The bench makes a higher request arrive in the same cycle as an acknowledge. A controller that does not freeze the vector there would hand the CPU the wrong address. It leaves the watchdog flag and its enable set while in watchdog mode. A design that honoured the enable there would raise 0xFFF4 next to the reset vector. It raises a non-maskable source with the global enable low, where a design that gated slot 14 on `gie_i` would stay silent. It also acknowledges a shared port vector and checks the flag is still set. Auto-clearing that flag would lose the other pin events behind it. A separate case applies a set and a clear to the same bit at once, where a clear-priority design would drop the event.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int NSRC     = 16;
  localparam int NSLOT    = 16;
  localparam int SLOT_W   = $clog2(NSLOT);
  localparam int VEC_W    = 16;
  localparam int RST_SLOT = NSLOT - 1;
  localparam int NMI_SLOT = NSLOT - 2;
  localparam int WDT_BIT  = 9;
  localparam logic [VEC_W-1:0] VEC_BASE    = 16'hFFE0;
  localparam logic [NSRC-1:0]  FLAG_RST    = 16'h4080;
  localparam logic [NSRC-1:0]  SINGLE_MASK = 16'h17A1;

  // slot 2 is left without a source; bits 13..15 share the NMI slot
  function automatic logic [SLOT_W-1:0] src_slot(int i);
    if (i < 2)       return SLOT_W'(i);
    else if (i < 13) return SLOT_W'(i + 1);
    else             return SLOT_W'(NMI_SLOT);
  endfunction

  function automatic logic [NSRC-1:0] slot_mask(int s);
    logic [NSRC-1:0] m;
    m = '0;
    for (int i = 0; i < NSRC; i++)
      if (src_slot(i) == SLOT_W'(s)) m[i] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank
  import irq_vec_pkg::*;
#(
  parameter int              N       = NSRC,
  parameter logic [N-1:0]    RST_VAL = FLAG_RST
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] sw_clr_i,
  input  logic [N-1:0] ack_clr_i,
  input  logic         ie_we_i,
  input  logic [N-1:0] ie_data_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] ie_o
);
  logic [N-1:0] flag_q, ie_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= RST_VAL;
      ie_q   <= '0;
    end else begin
      flag_q <= (flag_q & ~(sw_clr_i | ack_clr_i)) | set_i;
      if (ie_we_i) ie_q <= ie_data_i;
    end
  end

  assign flag_o = flag_q;
  assign ie_o   = ie_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((flag_o & $past(set_i)) == $past(set_i))); // R11
endmodule

// File: rtl/irq_slot_map.sv
module irq_slot_map
  import irq_vec_pkg::*;
#(
  parameter int N  = NSRC,
  parameter int NS = NSLOT
) (
  input  logic [N-1:0]  flag_i,
  input  logic [N-1:0]  ie_i,
  input  logic          gie_i,
  input  logic          wdt_intv_i,
  input  logic          rst_pend_i,
  output logic [NS-1:0] slot_req_o
);
  logic [N-1:0] hit;
  logic [N-1:0] wdt_gate;

  // watchdog enable only counts in interval mode
  assign wdt_gate = wdt_intv_i ? '1 : ~(N'(1) << WDT_BIT);
  assign hit      = flag_i & ie_i & wdt_gate;

  for (genvar s = 0; s < NS - 1; s++) begin : g_slot
    if (s == NMI_SLOT) begin : g_nmi
      assign slot_req_o[s] = |(hit & slot_mask(s));
    end else begin : g_mask
      assign slot_req_o[s] = gie_i & (|(hit & slot_mask(s)));
    end
  end
  assign slot_req_o[NS-1] = rst_pend_i;
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick
  import irq_vec_pkg::*;
#(
  parameter int NS = NSLOT,
  parameter int W  = $clog2(NS)
) (
  input  logic [NS-1:0] req_i,
  output logic          any_o,
  output logic [W-1:0]  idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int s = 0; s < NS; s++) begin
      if (req_i[s]) begin
        any_o = 1'b1;
        idx_o = W'(s);
      end
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gie_i,
  input  logic             sys_rst_req_i,
  input  logic             wdt_ovf_i,
  input  logic             wdt_intv_i,
  input  logic [NSRC-1:0]  flag_set_i,
  input  logic [NSRC-1:0]  flag_clr_i,
  input  logic             ie_we_i,
  input  logic [NSRC-1:0]  ie_data_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [NSRC-1:0]  flags_o,
  output logic [NSRC-1:0]  ie_o
);
  logic [NSRC-1:0]   flag_w, ie_w, set_vec, ack_clr;
  logic [NSLOT-1:0]  slot_req;
  logic [SLOT_W-1:0] win, slot_q;
  logic              any_req, irq_q, rst_pend_q, ack_ok, wdt_rst;

  assign ack_ok  = ack_i & irq_q;
  assign wdt_rst = wdt_ovf_i & ~wdt_intv_i;
  assign set_vec = flag_set_i | (NSRC'(wdt_ovf_i) << WDT_BIT);

  for (genvar g = 0; g < NSRC; g++) begin : g_ack
    if (SINGLE_MASK[g]) begin : g_single
      assign ack_clr[g] = ack_ok & (slot_q == src_slot(g));
    end else begin : g_shared
      assign ack_clr[g] = 1'b0;
    end
  end

  irq_flag_bank #(.N(NSRC), .RST_VAL(FLAG_RST)) u_flags (
    .clk_i, .rst_ni,
    .set_i     (set_vec),
    .sw_clr_i  (flag_clr_i),
    .ack_clr_i (ack_clr),
    .ie_we_i,
    .ie_data_i,
    .flag_o    (flag_w),
    .ie_o      (ie_w)
  );

  irq_slot_map #(.N(NSRC), .NS(NSLOT)) u_map (
    .flag_i     (flag_w),
    .ie_i       (ie_w),
    .gie_i,
    .wdt_intv_i,
    .rst_pend_i (rst_pend_q),
    .slot_req_o (slot_req)
  );

  irq_prio_pick #(.NS(NSLOT), .W(SLOT_W)) u_pick (
    .req_i (slot_req),
    .any_o (any_req),
    .idx_o (win)
  );

  // reset slot pending from power-up; a new request wins over the acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                           rst_pend_q <= 1'b1;
    else if (sys_rst_req_i || wdt_rst)                     rst_pend_q <= 1'b1;
    else if (ack_ok && slot_q == SLOT_W'(RST_SLOT))        rst_pend_q <= 1'b0;
  end

  // vector frozen during acknowledge, strobe dropped for one cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q  <= 1'b0;
      slot_q <= '0;
    end else if (ack_i) begin
      irq_q  <= 1'b0;
    end else begin
      irq_q  <= any_req;
      if (any_req) slot_q <= win;
    end
  end

  assign irq_o   = irq_q;
  assign vec_o   = VEC_BASE + VEC_W'({slot_q, 1'b0});
  assign flags_o = flag_w;
  assign ie_o    = ie_w;

  AST_PICK_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_req |-> (slot_req >> win) == NSLOT'(1)); // R4
  AST_RST_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rst_pend_q && !ack_i) |=> (irq_o && vec_o == 16'hFFFE)); // R2
  AST_GIE_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !$past(gie_i)) |-> (vec_o >= 16'hFFFC)); // R5
  AST_WDT_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !$past(wdt_intv_i)) |-> (vec_o != 16'hFFF4)); // R7
  AST_ACK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && ack_i) |=> (!irq_o && $stable(vec_o))); // R10
endmodule

// File: tb/irq_vec_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        gie_i = 1'b0, sys_rst_req_i = 1'b0, wdt_ovf_i = 1'b0, wdt_intv_i = 1'b0;
  logic [15:0] flag_set_i = '0, flag_clr_i = '0, ie_data_i = '0;
  logic        ie_we_i = 1'b0, ack_i = 1'b0;
  logic        irq_o;
  logic [15:0] vec_o, flags_o, ie_o;
  int errors = 0, checks = 0;

  always #5 clk_i = ~clk_i;

  irq_vec_ctrl u_dut (.*);

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk_i); #2; end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_vec(int b);
    int s;
    case (b)
      0: s = 0;   1: s = 1;   2: s = 3;   3: s = 4;   4: s = 5;   5: s = 6;
      6: s = 7;   7: s = 8;   8: s = 9;   9: s = 10;  10: s = 11; 11: s = 12;
      12: s = 13; default: s = 14;
    endcase
    return 16'hFFE0 + 16'(2 * s);
  endfunction

  task automatic pulse_set(logic [15:0] m);
    flag_set_i = m; step(); flag_set_i = '0;
  endtask

  task automatic write_ie(logic [15:0] d);
    ie_we_i = 1'b1; ie_data_i = d; step(); ie_we_i = 1'b0;
  endtask

  task automatic do_ack();
    ack_i = 1'b1; step(); ack_i = 1'b0;
  endtask

  task automatic cleanup();
    flag_clr_i = '1; step(); flag_clr_i = '0; step();
    if (irq_o) begin do_ack(); step(); end
  endtask

  task automatic t_reset();
    step(3);
    chk("R3 flags", flags_o, 16'h4080);
    chk("R3 ie", ie_o, 16'h0000);
    chk("R3 irq", irq_o, 0);
    rst_ni = 1'b1;
    step();
    chk("R2 irq", irq_o, 1);
    chk("R2 vec", vec_o, 16'hFFFE);
    do_ack();
    chk("R9 irq after ack", irq_o, 0);
    step();
    chk("R2 cleared", irq_o, 0);
  endtask

  task automatic t_prio();
    write_ie(16'h1FFF);
    step();
    chk("R5 gie low", irq_o, 0);
    gie_i = 1'b1; step();
    chk("R5 gie high irq", irq_o, 1);
    chk("R5 tx vec", vec_o, 16'hFFF0);
    pulse_set(16'h1000); step();
    chk("R4 higher wins", vec_o, 16'hFFFA);
    do_ack();
    chk("R9 irq low", irq_o, 0);
    chk("R10 vec held", vec_o, 16'hFFFA);
    chk("R8 single cleared", flags_o[12], 0);
    step();
    chk("R9 re-eval", vec_o, 16'hFFF0);
    do_ack();
    chk("R8 tx cleared", flags_o[7], 0);
    step();
    chk("R4 none left", irq_o, 0);
    chk("R8 flags", flags_o, 16'h4000);
  endtask

  task automatic t_shared();
    pulse_set(16'h0008); step();
    chk("R1 port1 vec", vec_o, 16'hFFE8);
    do_ack();
    chk("R8 shared kept", flags_o[3], 1);
    step();
    chk("R9 shared again", irq_o, 1);
    flag_clr_i = 16'h0008; step(); flag_clr_i = '0; step();
    chk("R11 sw clear", flags_o[3], 0);
    chk("R11 irq gone", irq_o, 0);
    flag_set_i = 16'h0001; flag_clr_i = 16'h0001; step();
    flag_set_i = '0; flag_clr_i = '0;
    chk("R11 set wins", flags_o[0], 1);
    cleanup();
  endtask

  task automatic t_stable();
    pulse_set(16'h0040); step();
    chk("R1 adc vec", vec_o, 16'hFFEE);
    ack_i = 1'b1; flag_set_i = 16'h1000; step();
    ack_i = 1'b0; flag_set_i = '0;
    chk("R10 held in ack", vec_o, 16'hFFEE);
    chk("R9 low after ack", irq_o, 0);
    step();
    chk("R4 late higher", vec_o, 16'hFFFA);
    cleanup();
  endtask

  task automatic t_nmi();
    gie_i = 1'b0;
    pulse_set(16'h2000); step(2);
    chk("R6 needs enable", irq_o, 0);
    chk("R6 flag set", flags_o[13], 1);
    write_ie(16'h3FFF); step();
    chk("R6 irq no gie", irq_o, 1);
    chk("R6 vec", vec_o, 16'hFFFC);
    do_ack();
    chk("R8 nmi kept", flags_o[13], 1);
    cleanup();
  endtask

  task automatic t_wdt();
    gie_i = 1'b1; wdt_intv_i = 1'b0;
    wdt_ovf_i = 1'b1; step(); wdt_ovf_i = 1'b0; step();
    chk("R7 wdt reset vec", vec_o, 16'hFFFE);
    chk("R7 wdt irq", irq_o, 1);
    chk("R7 wdt flag", flags_o[9], 1);
    do_ack(); step();
    chk("R7 enable ignored", irq_o, 0);
    wdt_intv_i = 1'b1; step();
    chk("R7 interval vec", vec_o, 16'hFFF4);
    do_ack();
    chk("R8 wdt cleared", flags_o[9], 0);
    step();
    chk("R7 done", irq_o, 0);
    cleanup();
  endtask

  task automatic t_sysrst();
    sys_rst_req_i = 1'b1; flag_set_i = 16'h1000; step();
    sys_rst_req_i = 1'b0; flag_set_i = '0; step();
    chk("R2 sys reset vec", vec_o, 16'hFFFE);
    do_ack(); step();
    chk("R4 next vec", vec_o, 16'hFFFA);
    cleanup();
  endtask

  task automatic t_map();
    write_ie(16'hFFFF); wdt_intv_i = 1'b1; gie_i = 1'b1;
    cleanup();
    chk("R1 idle", irq_o, 0);
    for (int b = 0; b < 16; b++) begin
      pulse_set(16'(1) << b); step();
      chk("R1 irq", irq_o, 1);
      chk("R1 map", vec_o, exp_vec(b));
      flag_clr_i = 16'(1) << b; step(); flag_clr_i = '0; step();
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    #2;
    t_reset();
    t_prio();
    t_shared();
    t_stable();
    t_nmi();
    t_wdt();
    t_sysrst();
    t_map();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule